// File: doc/BRIEF.md
# Debounced Jack-Detect Output Switcher

This block lets a level on a general-purpose pin, usually a headphone-jack sense switch, decide which of four audio outputs may be powered. The raw pin level is brought into the master-clock domain and then filtered by a debouncer. The debouncer looks at the pin only on a slow tick, which a free-running counter derives from the master clock. As a result, contact bounce and short glitches cannot make the output enables toggle repeatedly.

The filtered level chooses between two 4-bit masks: one applies while the jack level is low and the other while it is high. The chosen mask is ANDed with the four ordinary output enables that come from the register file. A mask can therefore switch outputs off but can never switch on an output that software left off. When detection is turned off, the masks are bypassed and the ordinary enables pass straight through. The final enables are registered.

Top module: `jack_out_switch`

## Requirements
- R1: The slow tick fires once every 2^TICK_BITS master-clock cycles (TICK_BITS defaults to 21) while `slow_clk_en` is 1. While `slow_clk_en` is 0, the tick counter is held at zero and no tick fires.
- R2: `jack_raw` passes through a two-flop synchronizer. `jack_level` takes a new value only on a slow tick, and only after the synchronized pin has shown that value at HOLD_TICKS (default 2) consecutive ticks. `jack_level` therefore cannot change within one tick period of a change on the pin.
- R3: A pulse on `jack_raw` shorter than one tick period leaves `jack_level` unchanged.
- R4: While `slow_clk_en` is 0, `jack_level` holds its value whatever `jack_raw` does.
- R5: While `rst` is 1 (synchronous, active high), `jack_level` is 0 and `out_en` is 0. After reset, the low-level mask applies until a debounced change occurs.
- R6: With `jd_enable` = 1, bit i of `out_en` equals bit i of `out_en_req` ANDed with bit i of `mask_when_low` when `jack_level` is 0, or with bit i of `mask_when_high` when `jack_level` is 1. A mask bit of 0 forces that output off.
- R7: With `jd_enable` = 0, `out_en` equals `out_en_req` and both masks are ignored.
- R8: `out_en` is registered. It reflects the control inputs and `jack_level` one master-clock cycle after they change.
- R9: No bit of `out_en` is ever 1 while the matching bit of `out_en_req` was 0 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| jack_raw | input | 1 | Raw jack-sense pin level, asynchronous |
| slow_clk_en | input | 1 | Runs the slow tick generator |
| jd_enable | input | 1 | Applies the jack-detect masks when 1 |
| mask_when_low | input | NUM_OUTS (4) | Per-output permission while the jack level is 0 |
| mask_when_high | input | NUM_OUTS (4) | Per-output permission while the jack level is 1 |
| out_en_req | input | NUM_OUTS (4) | Ordinary output enables from the register file |
| out_en | output | NUM_OUTS (4) | Final registered output enables |
| jack_level | output | 1 | Debounced jack level |

## Verification
The bench sends a glitch shorter than a tick period. A design that samples the pin every cycle, or that does not clear its hold count, would flip `jack_level` on that glitch. The bench also checks that `jack_level` has not moved shortly after a real pin change, which catches a debouncer that accepts a single tick sample. With the tick disabled, the bench moves the pin and expects `jack_level` to stay frozen. The mask table covers cases where a mask bit of 1 meets an ordinary enable of 0, cases that pick the wrong mask for each level, and the bypass when detection is off. A design that used OR instead of AND, swapped the masks, or let the masks act while detection was off would fail these entries.

// File: rtl/jd_pkg.sv
package jd_pkg;
  localparam int unsigned NUM_OUTS_DEF = 4;

  function automatic logic [NUM_OUTS_DEF-1:0] pick_mask(
    input logic                    lvl,
    input logic [NUM_OUTS_DEF-1:0] m_low,
    input logic [NUM_OUTS_DEF-1:0] m_high
  );
    return lvl ? m_high : m_low;
  endfunction
endpackage

// File: rtl/jd_slow_tick.sv
module jd_slow_tick #(
  parameter int unsigned TICK_BITS = 21
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick,
  output logic [TICK_BITS-1:0] count
);
  localparam logic [TICK_BITS-1:0] LAST = {TICK_BITS{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

  assign tick = run && (count == LAST);
endmodule

// File: rtl/jd_sync.sv
module jd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/jd_debounce.sv
module jd_debounce #(
  parameter int unsigned HOLD_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sample,
  output logic level
);
  localparam int unsigned CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CW-1:0] LAST_HOLD = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      seen  <= '0;
    end else if (tick) begin
      if (sample != level) begin
        if (seen == LAST_HOLD) begin
          level <= sample;
          seen  <= '0;
        end else begin
          seen <= seen + 1'b1;
        end
      end else begin
        seen <= '0;
      end
    end
  end
endmodule

// File: rtl/jd_enable_gate.sv
module jd_enable_gate
  import jd_pkg::*;
#(
  parameter int unsigned NUM_OUTS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                level,
  input  logic                gate_on,
  input  logic [NUM_OUTS-1:0] m_low,
  input  logic [NUM_OUTS-1:0] m_high,
  input  logic [NUM_OUTS-1:0] req,
  output logic [NUM_OUTS-1:0] en_q
);
  logic [NUM_OUTS-1:0] allow;

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_out
    always_comb begin
      if (!gate_on) begin
        allow[i] = 1'b1;
      end else begin
        allow[i] = level ? m_high[i] : m_low[i];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[i] <= 1'b0;
      end else begin
        en_q[i] <= req[i] & allow[i];
      end
    end
  end
endmodule

// File: rtl/jack_out_switch.sv
module jack_out_switch #(
  parameter int unsigned NUM_OUTS    = 4,
  parameter int unsigned TICK_BITS   = 21,
  parameter int unsigned HOLD_TICKS  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                jack_raw,
  input  logic                slow_clk_en,
  input  logic                jd_enable,
  input  logic [NUM_OUTS-1:0] mask_when_low,
  input  logic [NUM_OUTS-1:0] mask_when_high,
  input  logic [NUM_OUTS-1:0] out_en_req,
  output logic [NUM_OUTS-1:0] out_en,
  output logic                jack_level
);
  logic                 slow_tick;
  logic [TICK_BITS-1:0] tick_cnt;
  logic                 pin_sync;

  jd_slow_tick #(.TICK_BITS(TICK_BITS)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (slow_clk_en),
    .tick (slow_tick),
    .count(tick_cnt)
  );

  jd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (jack_raw),
    .dout(pin_sync)
  );

  jd_debounce #(.HOLD_TICKS(HOLD_TICKS)) u_deb (
    .clk   (clk),
    .rst   (rst),
    .tick  (slow_tick),
    .sample(pin_sync),
    .level (jack_level)
  );

  jd_enable_gate #(.NUM_OUTS(NUM_OUTS)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .level  (jack_level),
    .gate_on(jd_enable),
    .m_low  (mask_when_low),
    .m_high (mask_when_high),
    .req    (out_en_req),
    .en_q   (out_en)
  );
endmodule

// File: rtl/jack_out_switch_chk.sv
module jack_out_switch_chk #(
  parameter int unsigned NUM_OUTS  = 4,
  parameter int unsigned TICK_BITS = 21
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 slow_clk_en,
  input logic                 jd_enable,
  input logic [NUM_OUTS-1:0]  mask_when_low,
  input logic [NUM_OUTS-1:0]  mask_when_high,
  input logic [NUM_OUTS-1:0]  out_en_req,
  input logic [NUM_OUTS-1:0]  out_en,
  input logic                 jack_level,
  input logic                 slow_tick,
  input logic [TICK_BITS-1:0] tick_cnt
);
  p_cnt_held_r1: assert property (@(posedge clk) disable iff (rst)
    (!slow_clk_en) |=> (tick_cnt == '0));

  p_level_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (!slow_tick) |=> $stable(jack_level));

  p_level_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (!slow_clk_en) |=> $stable(jack_level));

  p_reset_state_r5: assert property (@(posedge clk)
    rst |=> (jack_level == 1'b0 && out_en == '0));

  p_mask_select_r6: assert property (@(posedge clk) disable iff (rst)
    (jd_enable) |=> (out_en == ($past(out_en_req) &
      ($past(jack_level) ? $past(mask_when_high) : $past(mask_when_low)))));

  p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
    (!jd_enable) |=> (out_en == $past(out_en_req)));

  p_only_remove_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((out_en & ~$past(out_en_req)) == '0));
endmodule

bind jack_out_switch jack_out_switch_chk #(
  .NUM_OUTS (NUM_OUTS),
  .TICK_BITS(TICK_BITS)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .slow_clk_en   (slow_clk_en),
  .jd_enable     (jd_enable),
  .mask_when_low (mask_when_low),
  .mask_when_high(mask_when_high),
  .out_en_req    (out_en_req),
  .out_en        (out_en),
  .jack_level    (jack_level),
  .slow_tick     (slow_tick),
  .tick_cnt      (tick_cnt)
);

// File: tb/tb_jack_out_switch.sv
module tb_jack_out_switch;
  localparam int TB_TICK_BITS = 4;
  localparam int PERIOD_CYC   = 1 << TB_TICK_BITS;
  localparam int NV           = 9;

  // fields: lvl, jd, mask_low[4], mask_high[4], req[4], expected[4]
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'b0000, 4'b0000, 4'b1111, 4'b1111},
    {1'b0, 1'b1, 4'b1010, 4'b0101, 4'b1111, 4'b1010},
    {1'b0, 1'b1, 4'b0000, 4'b1111, 4'b1111, 4'b0000},
    {1'b0, 1'b1, 4'b1111, 4'b0000, 4'b0110, 4'b0110},
    {1'b0, 1'b1, 4'b1100, 4'b0011, 4'b0101, 4'b0100},
    {1'b1, 1'b1, 4'b1010, 4'b0101, 4'b1111, 4'b0101},
    {1'b1, 1'b1, 4'b0000, 4'b0011, 4'b1001, 4'b0001},
    {1'b1, 1'b0, 4'b0000, 4'b0000, 4'b1011, 4'b1011},
    {1'b1, 1'b1, 4'b1111, 4'b1111, 4'b0000, 4'b0000}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       jack_raw = 1'b0;
  logic       slow_clk_en = 1'b1;
  logic       jd_enable = 1'b1;
  logic [3:0] mask_when_low = 4'b0011;
  logic [3:0] mask_when_high = 4'b1100;
  logic [3:0] out_en_req = 4'b1111;
  logic [3:0] out_en;
  logic       jack_level;

  int total = 0;
  int bad = 0;
  logic cur_lvl = 1'b0;

  always #2.5 clk = ~clk;

  jack_out_switch #(.NUM_OUTS(4), .TICK_BITS(TB_TICK_BITS), .HOLD_TICKS(2)) dut (
    .clk(clk), .rst(rst), .jack_raw(jack_raw), .slow_clk_en(slow_clk_en),
    .jd_enable(jd_enable), .mask_when_low(mask_when_low),
    .mask_when_high(mask_when_high), .out_en_req(out_en_req),
    .out_en(out_en), .jack_level(jack_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Move the pin, confirm no early change (R2), then confirm the change.
  task automatic move_level(input logic v);
    jack_raw = v;
    cyc(PERIOD_CYC - 2);
    chk("R2 early", {31'b0, jack_level}, {31'b0, cur_lvl});
    cyc(3 * PERIOD_CYC);
    cur_lvl = v;
    chk("R2 settle", {31'b0, jack_level}, {31'b0, cur_lvl});
  endtask

  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      cnt++;
      if (cnt > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cnt);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R5 reset state
    cyc(3);
    chk("R5 level", {31'b0, jack_level}, 32'd0);
    chk("R5 out_en", {28'b0, out_en}, 32'd0);
    rst = 1'b0;
    cyc(1);
    chk("R5 low mask after reset", {28'b0, out_en}, 32'h3);

    // Vector table: R6, R7, R9
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      if (v[17] != cur_lvl) move_level(v[17]);
      jd_enable      = v[16];
      mask_when_low  = v[15:12];
      mask_when_high = v[11:8];
      out_en_req     = v[7:4];
      cyc(1);
      chk(v[16] ? "R6 mask vector" : "R7 bypass vector", {28'b0, out_en}, {28'b0, v[3:0]});
      chk("R9 subset", {28'b0, out_en & ~v[7:4]}, 32'd0);
    end

    // R8 registered latency (level is 1 here)
    jd_enable = 1'b1; mask_when_high = 4'b1111; out_en_req = 4'b1111;
    cyc(1);
    out_en_req = 4'b0010;
    #1;
    chk("R8 before edge", {28'b0, out_en}, 32'hF);
    cyc(1);
    chk("R8 after edge", {28'b0, out_en}, 32'h2);

    // R3 short glitch toward 0 while level is 1
    jack_raw = 1'b0;
    cyc(3);
    jack_raw = 1'b1;
    cyc(4 * PERIOD_CYC);
    chk("R3 glitch ignored", {31'b0, jack_level}, 32'd1);
    chk("R3 outputs kept", {28'b0, out_en}, 32'h2);

    // R4 and R1: tick stopped, pin moves, level frozen
    slow_clk_en = 1'b0;
    jack_raw = 1'b0;
    cyc(6 * PERIOD_CYC);
    chk("R4 frozen level", {31'b0, jack_level}, 32'd1);
    // R1: after re-enable, the first tick comes PERIOD_CYC cycles later
    slow_clk_en = 1'b1;
    cyc(PERIOD_CYC - 2);
    chk("R1 no tick yet", {31'b0, jack_level}, 32'd1);
    cyc(PERIOD_CYC + 4);
    chk("R1 resumed ticks", {31'b0, jack_level}, 32'd0);
    cur_lvl = 1'b0;

    // R6 low mask in use again
    mask_when_low = 4'b1001; out_en_req = 4'b1111; jd_enable = 1'b1;
    cyc(1);
    chk("R6 low mask again", {28'b0, out_en}, 32'h9);

    // R5 reset mid-run
    move_level(1'b1);
    rst = 1'b1;
    cyc(1);
    chk("R5 level on reset", {31'b0, jack_level}, 32'd0);
    chk("R5 out on reset", {28'b0, out_en}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule